// File: doc/BRIEF.md
# Framebuffer to Bit-Plane Transposer

This block reorganises a frame of per-channel brightness values into bit-plane words for a binary code modulation output stage. A bit-plane word collects the same bit weight from every channel. A modulation engine can then shift that word out unchanged during the time slot for that weight. The framebuffer stores one value per channel, each `VAL_W` bits wide. Only the top `NPLANES` bits of each value are used. Plane 0 takes the least significant of those bits and the top plane takes the most significant.

The surrounding logic pulses `frame_new` whenever a fresh frame has landed in the framebuffer. That pulse sets an internal pending flag. When the block is idle and the flag is set, it clears the flag and starts a pass. A pass reads every channel once through a synchronous read port, in ascending order, and builds all plane words in parallel. It then writes the planes out one per cycle and closes with a one-cycle done pulse. A frame that arrives while a pass is running sets the flag again, so a second pass follows straight away and the planes never stay stale.

Top module: `bitplane_xpose`

## Requirements
- R1: After reset, `busy`, `done`, `fb_rd_en` and `pl_wr_en` are all low, and no pass starts until `frame_new` has been pulsed.
- R2: The word written for plane p has bit j equal to bit (p + VAL_W − NPLANES) of channel j's value. Channel 0 maps to bit 0. Value bits below position VAL_W − NPLANES have no effect on any plane.
- R3: During a pass the block reads each channel address from 0 to NCHAN−1 exactly once, in ascending order, one address per cycle. It expects the read data one cycle after `fb_rd_en`.
- R4: After the last read, the block writes planes 0 to NPLANES−1 in ascending address order, one per cycle, with no gaps. It never reads and writes in the same cycle.
- R5: `done` is high for exactly one cycle, in the cycle after the last plane write. `busy` is high from the cycle after a pass starts up to and including the done cycle. At the defaults that is NCHAN+1+NPLANES+1 = 48 cycles.
- R6: A `frame_new` pulse starts exactly one pass, and the start clears the pending flag. With no further pulse, no further reads or writes happen.
- R7: A `frame_new` pulse that arrives while a pass is running, or in the cycle a pass starts, causes exactly one more pass after the current one. That pass reads the framebuffer contents as they are at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_new | input | 1 | One-cycle pulse: framebuffer content changed |
| fb_rd_en | output | 1 | Framebuffer read strobe |
| fb_rd_addr | output | $clog2(NCHAN) | Channel index being read |
| fb_rd_data | input | VAL_W | Channel value, valid one cycle after the strobe |
| pl_wr_en | output | 1 | Plane write strobe |
| pl_wr_addr | output | $clog2(NPLANES) | Plane index being written |
| pl_wr_data | output | NCHAN | Plane word, bit j from channel j |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle pulse ending a pass |

## Verification
The bench targets value patterns that expose bit-selection mistakes:
- Values with only the bits below the offset set must produce all-zero planes. A design that selects from the bottom of the value instead of the top fills the planes.
- Walking-one channel patterns catch a channel-to-bit reversal or an off-by-one in the capture index. Such a fault would place a channel's bit one position away or mirror it across the word.

A `frame_new` pulse on the exact start cycle, and another in the middle of the write phase with the framebuffer changed, check the re-arm rule. A design that clears the flag at done, or lets the start overwrite a same-cycle pulse, runs one pass too few.

The bench also counts the reads, writes and busy cycles in every pass. A read-data latency slip or a lost last channel then shows up as wrong plane words or a wrong cycle count.

// File: rtl/bitplane_xpose.sv
module bitplane_xpose #(
  parameter int NCHAN   = 32,
  parameter int NPLANES = 14,
  parameter int VAL_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_new,
  output logic                       fb_rd_en,
  output logic [$clog2(NCHAN)-1:0]   fb_rd_addr,
  input  logic [VAL_W-1:0]           fb_rd_data,
  output logic                       pl_wr_en,
  output logic [$clog2(NPLANES)-1:0] pl_wr_addr,
  output logic [NCHAN-1:0]           pl_wr_data,
  output logic                       busy,
  output logic                       done
);
  localparam int AW  = $clog2(NCHAN);
  localparam int PW  = $clog2(NPLANES);
  localparam int CW  = $clog2(NCHAN + 1) > PW ? $clog2(NCHAN + 1) : PW;
  localparam int OFS = VAL_W - NPLANES;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_DONE} state_t;

  state_t          state;
  logic [CW-1:0]   cnt;
  logic            pending;
  logic            cap_v;
  logic [AW-1:0]   cap_idx;
  logic [NCHAN-1:0] acc [NPLANES];
  logic            start;

  assign start      = (state == S_IDLE) && pending;
  assign fb_rd_en   = (state == S_READ) && (cnt < CW'(NCHAN));
  assign fb_rd_addr = cnt[AW-1:0];
  assign pl_wr_en   = (state == S_WRITE);
  assign pl_wr_addr = cnt[PW-1:0];
  assign pl_wr_data = acc[cnt[PW-1:0]];
  assign busy       = (state != S_IDLE);
  assign done       = (state == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (frame_new)  pending <= 1'b1;
      else if (start) pending <= 1'b0;
      case (state)
        S_IDLE:
          if (pending) begin
            state <= S_READ;
            cnt   <= '0;
          end
        S_READ:
          if (cnt == CW'(NCHAN)) begin
            state <= S_WRITE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        S_WRITE:
          if (cnt == CW'(NPLANES - 1)) begin
            state <= S_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v   <= 1'b0;
      cap_idx <= '0;
    end else begin
      cap_v   <= fb_rd_en;
      cap_idx <= fb_rd_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (cap_v) begin
      for (int p = 0; p < NPLANES; p++)
        acc[p][cap_idx] <= fb_rd_data[p + OFS];
    end
  end

  // R1
  idle_after_reset_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> !busy && !fb_rd_en && !pl_wr_en);

  // R3
  rd_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_rd_en && $past(fb_rd_en) |-> fb_rd_addr == $past(fb_rd_addr) + 1'b1);

  // R3
  rd_first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fb_rd_en) |-> fb_rd_addr == '0);

  // R4
  wr_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_wr_en && $past(pl_wr_en) |-> pl_wr_addr == $past(pl_wr_addr) + 1'b1);

  // R4
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fb_rd_en && pl_wr_en));

  // R5
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(pl_wr_en) && $past(pl_wr_addr) == PW'(NPLANES - 1));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R6
  start_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(pending));
endmodule

// File: tb/test_bitplane_xpose.sv
module test_bitplane_xpose;
  localparam int NCHAN = 32, NPLANES = 14, VAL_W = 16;
  localparam int OFS = VAL_W - NPLANES;
  localparam int PASS_CYC = NCHAN + 1 + NPLANES + 1;

  logic clk = 1'b0, rst_n = 1'b0, frame_new = 1'b0;
  logic fb_rd_en, pl_wr_en, busy, done;
  logic [4:0] fb_rd_addr;
  logic [3:0] pl_wr_addr;
  logic [VAL_W-1:0] fb_rd_data;
  logic [NCHAN-1:0] pl_wr_data;

  logic [VAL_W-1:0] mem [NCHAN];
  logic [NCHAN-1:0] got [NPLANES];
  logic [NCHAN-1:0] expv [NPLANES];
  int checks = 0, errors = 0;
  int rd_cnt, wr_cnt, busy_cyc, done_cnt, seq_err;
  int rd_next, wr_next;

  always #10 clk = ~clk;

  bitplane_xpose i_bitplane_xpose (
    .clk(clk), .rst_n(rst_n), .frame_new(frame_new),
    .fb_rd_en(fb_rd_en), .fb_rd_addr(fb_rd_addr), .fb_rd_data(fb_rd_data),
    .pl_wr_en(pl_wr_en), .pl_wr_addr(pl_wr_addr), .pl_wr_data(pl_wr_data),
    .busy(busy), .done(done)
  );

  always @(posedge clk) if (fb_rd_en) fb_rd_data <= mem[fb_rd_addr];

  always @(negedge clk) begin
    if (rst_n) begin
      if (fb_rd_en) begin
        if (int'(fb_rd_addr) != rd_next) seq_err++;
        rd_next = (rd_next + 1) % NCHAN;
        rd_cnt++;
      end
      if (pl_wr_en) begin
        if (int'(pl_wr_addr) != wr_next) seq_err++;
        got[pl_wr_addr] = pl_wr_data;
        wr_next = (wr_next + 1) % NPLANES;
        wr_cnt++;
      end
      if (busy) busy_cyc++;
      if (done) done_cnt++;
    end
  end

  function automatic logic [NCHAN-1:0] plane_of(int p);
    logic [NCHAN-1:0] w;
    for (int j = 0; j < NCHAN; j++) w[j] = mem[j][p + OFS];
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_stats();
    rd_cnt = 0; wr_cnt = 0; busy_cyc = 0; done_cnt = 0; seq_err = 0;
    rd_next = 0; wr_next = 0;
  endtask

  task automatic snap_expected();
    for (int p = 0; p < NPLANES; p++) expv[p] = plane_of(p);
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame_new = 1'b1;
    @(negedge clk); frame_new = 1'b0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    check(done, "R5", "done seen before timeout", done, 1);
    @(negedge clk);
  endtask

  task automatic check_planes(input string req);
    for (int p = 0; p < NPLANES; p++)
      check(got[p] === expv[p], req, $sformatf("plane %0d", p), got[p], expv[p]);
  endtask

  task automatic check_pass_shape(input int passes);
    check(rd_cnt == passes * NCHAN, "R3", "read count", rd_cnt, passes * NCHAN);
    check(wr_cnt == passes * NPLANES, "R4", "write count", wr_cnt, passes * NPLANES);
    check(seq_err == 0, "R4", "address order errors", seq_err, 0);
    check(done_cnt == passes, "R5", "done cycles", done_cnt, passes);
    check(busy_cyc == passes * PASS_CYC, "R5", "busy cycles", busy_cyc, passes * PASS_CYC);
  endtask

  task automatic run_one(input string req);
    clear_stats();
    snap_expected();
    pulse_frame();
    wait_done();
    repeat (5) @(negedge clk);
    check_planes(req);
    check_pass_shape(1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int j = 0; j < NCHAN; j++) mem[j] = '0;
    fb_rd_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_stats();
    @(negedge clk);
    check(!busy && !done && !fb_rd_en && !pl_wr_en, "R1", "idle outputs after reset",
          {busy, done, fb_rd_en, pl_wr_en}, 0);
    repeat (20) @(negedge clk);
    check(rd_cnt == 0 && busy_cyc == 0, "R1", "no pass without frame_new", rd_cnt, 0);

    for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'($urandom);
    run_one("R2");

    for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'((1 << OFS) - 1);
    run_one("R2");

    for (int j = 0; j < NCHAN; j++) mem[j] = '1;
    run_one("R2");

    for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'(1 << (OFS + (j % NPLANES)));
    run_one("R2");

    clear_stats();
    repeat (30) @(negedge clk);
    check(rd_cnt == 0 && wr_cnt == 0, "R6", "no extra pass after flag cleared", rd_cnt + wr_cnt, 0);

    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'($urandom);
      run_one("R2");
    end

    clear_stats();
    for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'($urandom);
    snap_expected();
    pulse_frame();
    while (!pl_wr_en) @(negedge clk);
    for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'($urandom);
    frame_new = 1'b1;
    @(negedge clk); frame_new = 1'b0;
    wait_done();
    check_planes("R7");
    snap_expected();
    wait_done();
    repeat (5) @(negedge clk);
    check_planes("R7");
    check_pass_shape(2);

    clear_stats();
    for (int j = 0; j < NCHAN; j++) mem[j] = VAL_W'($urandom);
    snap_expected();
    @(negedge clk); frame_new = 1'b1;
    @(negedge clk);
    @(negedge clk); frame_new = 1'b0;
    wait_done();
    wait_done();
    repeat (60) @(negedge clk);
    check_planes("R7");
    check_pass_shape(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule